// File: doc/BRIEF.md
# Pin-Requested Power-Down Freeze Unit

This unit sits between a logic core and its pins and freezes both sides while a low-power state is requested on a pin. Two request pins exist. When the feature is switched on by a configuration input, a high level on either pin makes the unit snapshot the core's input vector, output data and output enables on the next clock edge. From then on it holds all three, and it stops the core clock through a gate enable. Pin changes have no effect on the core until the request drops and the unit finishes its release sequence.

Leaving the state is tied to the system clock. The request must be seen low on a programmable number of consecutive edges plus one before the core clock restarts and the live values pass through again. If the request comes back during that count, the unit stays frozen and the count starts over. With the feature switched on, the two request pins are taken away from the core: their bits in the core input vector read zero. With it switched off, they are ordinary inputs and the unit never freezes. Every logic input also has a keeper. A pin marked as undriven presents the last level that was driven on it. The reduced supply current is not modelled; a status flag stands in for it.

Top module: `pwrdn_hold`

## Requirements
- R1: While reset is high and after it, `pd_active` is 0, `core_clk_en` is 1, `pad_out`/`pad_oe` equal `core_out`/`core_oe`, and keeper state is 0.
- R2: With `pd_en` = 1, a clock edge that samples `pd_pin_a` or `pd_pin_b` high sets `pd_active` to 1 and `core_clk_en` to 0 right after that edge.
- R3: The frozen `core_in`, `pad_out` and `pad_oe` equal the values those ports showed in the cycle just before the entry edge.
- R4: While `pd_active` stays 1, `core_in`, `pad_out` and `pad_oe` do not change, whatever the pins, `core_out` and `core_oe` do.
- R5: An output whose enable bit was 0 at entry keeps `pad_oe` at 0 for the whole frozen period.
- R6: `pd_active` clears only after the request (`pd_en` and either pin high) has been sampled low on SYNC_STAGES+1 consecutive edges. A request seen again during that count keeps the unit frozen and restarts the count. With the default SYNC_STAGES = 2, that is three edges.
- R7: With `pd_en` = 1, bits IN_W (pin a) and IN_W+1 (pin b) of `core_in` read 0 while the unit is running.
- R8: With `pd_en` = 0, `pd_pin_a` appears on `core_in` bit IN_W, `pd_pin_b` on bit IN_W+1, and the pins never set `pd_active`.
- R9: For each logic input with `pin_drv` bit 0, `core_in` shows the level last latched on an edge where that bit was driven. Bits with `pin_drv` 1 show `pin_in` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_en | input | 1 | Configuration: power-down pins act as request pins |
| pd_pin_a | input | 1 | First power-down request pin |
| pd_pin_b | input | 1 | Second power-down request pin |
| pin_in | input | IN_W | Logic input pin levels |
| pin_drv | input | IN_W | Per-pin flag: 1 = pin is driven, 0 = floating |
| core_out | input | OUT_W | Output data from the core |
| core_oe | input | OUT_W | Output enables from the core |
| core_in | output | IN_W+2 | Gated input vector to the core (request pins on top two bits) |
| core_clk_en | output | 1 | Core clock gate enable |
| pad_out | output | OUT_W | Output data to the pads |
| pad_oe | output | OUT_W | Output enables to the pads |
| pd_active | output | 1 | Low-power status flag |

## Verification
Two functions can fall on the same edge, and the bench provokes both. In the first, the release count is running and the request rises again on that edge. The bench drops pin a for one cycle, raises it, then drops it again. It checks that `pd_active` stays high until three fresh low samples have been seen, and that the held values do not move. In the second, the entry edge coincides with new values on `core_out`, `core_oe` and the pins. The bench changes all of them in the very next cycle. It then checks that the frozen values are those from before the edge, and that the request-pin bits in the snapshot are masked to zero.

// File: rtl/pwrdn_hold_pkg.sv
package pwrdn_hold_pkg;

    typedef enum logic [1:0] {
        PDH_RUN  = 2'd0,
        PDH_HOLD = 2'd1,
        PDH_WAKE = 2'd2
    } pdh_state_e;

    function automatic logic pdh_request(input logic en, input logic a, input logic b);
        return en & (a | b);
    endfunction

    function automatic logic [1:0] pdh_pin_bits(input logic en, input logic a, input logic b);
        return en ? 2'b00 : {b, a};
    endfunction

endpackage

// File: rtl/pwrdn_hold_keeper.sv
module pwrdn_hold_keeper #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_drv,
    output logic [W-1:0] level
);
    logic [W-1:0] kept_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                kept_q[i] <= 1'b0;
            end else if (pin_drv[i]) begin
                kept_q[i] <= pin_in[i];
            end
        end

        assign level[i] = pin_drv[i] ? pin_in[i] : kept_q[i];
    end
endmodule

// File: rtl/pwrdn_hold_ctrl.sv
module pwrdn_hold_ctrl
    import pwrdn_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic frozen
);
    localparam int unsigned CW = $clog2(SYNC_STAGES + 1);

    pdh_state_e state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PDH_RUN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PDH_RUN: begin
                    if (req) state_q <= PDH_HOLD;
                    cnt_q <= '0;
                end
                PDH_HOLD: begin
                    if (!req) begin
                        state_q <= PDH_WAKE;
                        cnt_q   <= CW'(1);
                    end
                end
                PDH_WAKE: begin
                    if (req) begin
                        state_q <= PDH_HOLD;
                        cnt_q   <= '0;
                    end else if (cnt_q == CW'(SYNC_STAGES)) begin
                        state_q <= PDH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_q <= PDH_RUN;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign frozen = (state_q != PDH_RUN);
endmodule

// File: rtl/pwrdn_hold_freeze.sv
module pwrdn_hold_freeze #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] live,
    output logic [W-1:0] shown
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (!hold) begin
            snap_q <= live;
        end
    end

    assign shown = hold ? snap_q : live;
endmodule

// File: rtl/pwrdn_hold.sv
module pwrdn_hold
    import pwrdn_hold_pkg::*;
#(
    parameter int unsigned IN_W        = 4,
    parameter int unsigned OUT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_en,
    input  logic              pd_pin_a,
    input  logic              pd_pin_b,
    input  logic [IN_W-1:0]   pin_in,
    input  logic [IN_W-1:0]   pin_drv,
    input  logic [OUT_W-1:0]  core_out,
    input  logic [OUT_W-1:0]  core_oe,
    output logic [IN_W+1:0]   core_in,
    output logic              core_clk_en,
    output logic [OUT_W-1:0]  pad_out,
    output logic [OUT_W-1:0]  pad_oe,
    output logic              pd_active
);
    localparam int unsigned CIN_W = IN_W + 2;

    logic              req;
    logic              frozen;
    logic [IN_W-1:0]   kept_lvl;
    logic [CIN_W-1:0]  live_in;

    assign req = pdh_request(pd_en, pd_pin_a, pd_pin_b);

    pwrdn_hold_keeper #(.W(IN_W)) keeper_i (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .pin_drv (pin_drv),
        .level   (kept_lvl)
    );

    pwrdn_hold_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .frozen (frozen)
    );

    assign live_in = {pdh_pin_bits(pd_en, pd_pin_a, pd_pin_b), kept_lvl};

    pwrdn_hold_freeze #(.W(CIN_W)) frz_in_i (
        .clk   (clk),
        .rst   (rst),
        .hold  (frozen),
        .live  (live_in),
        .shown (core_in)
    );

    pwrdn_hold_freeze #(.W(OUT_W)) frz_out_i (
        .clk   (clk),
        .rst   (rst),
        .hold  (frozen),
        .live  (core_out),
        .shown (pad_out)
    );

    pwrdn_hold_freeze #(.W(OUT_W)) frz_oe_i (
        .clk   (clk),
        .rst   (rst),
        .hold  (frozen),
        .live  (core_oe),
        .shown (pad_oe)
    );

    assign core_clk_en = ~frozen;
    assign pd_active   = frozen;
endmodule

// File: rtl/pwrdn_hold_chk.sv
module pwrdn_hold_chk #(
    parameter int unsigned IN_W  = 4,
    parameter int unsigned OUT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pd_en,
    input logic              pd_pin_a,
    input logic              pd_pin_b,
    input logic [OUT_W-1:0]  core_out,
    input logic [IN_W+1:0]   core_in,
    input logic              core_clk_en,
    input logic [OUT_W-1:0]  pad_out,
    input logic [OUT_W-1:0]  pad_oe,
    input logic              pd_active
);
    logic req_seen;
    assign req_seen = pd_en & (pd_pin_a | pd_pin_b);

    AST_ENTER_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        req_seen |=> pd_active); // R2

    AST_CLOCK_RUNS: assert property (@(posedge clk) disable iff (rst)
        !pd_active |-> core_clk_en); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pd_active && $past(pd_active)) |-> ($stable(core_in) && $stable(pad_out) && $stable(pad_oe))); // R4

    AST_HIZ_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pd_active && $past(pd_active)) |-> ((pad_oe & ~$past(pad_oe)) == '0)); // R5

    AST_NO_EARLY_WAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_active) |-> (!$past(req_seen) && !$past(req_seen, 2))); // R6

    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (rst)
        (pd_en && !pd_active) |-> (core_in[IN_W+1:IN_W] == 2'b00)); // R7

    AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!pd_en && !pd_active) |-> (core_in[IN_W+1:IN_W] == {pd_pin_b, pd_pin_a} && pad_out == core_out)); // R8
endmodule

bind pwrdn_hold pwrdn_hold_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .pd_en       (pd_en),
    .pd_pin_a    (pd_pin_a),
    .pd_pin_b    (pd_pin_b),
    .core_out    (core_out),
    .core_in     (core_in),
    .core_clk_en (core_clk_en),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pd_active   (pd_active)
);

// File: tb/pwrdn_hold_tb_top.sv
module pwrdn_hold_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_en = 1'b0, pd_pin_a = 1'b0, pd_pin_b = 1'b0;
    logic [3:0] pin_in = '0, pin_drv = '0, core_out = '0, core_oe = '0;
    logic [5:0] core_in;
    logic       core_clk_en, pd_active;
    logic [3:0] pad_out, pad_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [5:0] cin;
        logic [3:0] po;
        logic [3:0] oe;
        logic       ce;
        logic       act;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    pwrdn_hold #(.IN_W(4), .OUT_W(4), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .pd_en       (pd_en),
        .pd_pin_a    (pd_pin_a),
        .pd_pin_b    (pd_pin_b),
        .pin_in      (pin_in),
        .pin_drv     (pin_drv),
        .core_out    (core_out),
        .core_oe     (core_oe),
        .core_in     (core_in),
        .core_clk_en (core_clk_en),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pd_active   (pd_active)
    );

    // monitor: compares in the middle of the high phase after each edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (core_in !== e.cin || pad_out !== e.po || pad_oe !== e.oe ||
                core_clk_en !== e.ce || pd_active !== e.act) begin
                n_fail++;
                $display("FAIL %s: got cin=%h po=%h oe=%h ce=%b act=%b exp cin=%h po=%h oe=%h ce=%b act=%b",
                         e.tag, core_in, pad_out, pad_oe, core_clk_en, pd_active,
                         e.cin, e.po, e.oe, e.ce, e.act);
            end
        end
    end

    task automatic cyc(input logic en, input logic a, input logic b,
                       input logic [3:0] drv, input logic [3:0] pin,
                       input logic [3:0] cout, input logic [3:0] coe,
                       input logic [5:0] xcin, input logic [3:0] xpo,
                       input logic [3:0] xoe, input logic xce, input logic xact,
                       input string tag);
        exp_t e;
        @(negedge clk);
        pd_en = en; pd_pin_a = a; pd_pin_b = b;
        pin_drv = drv; pin_in = pin; core_out = cout; core_oe = coe;
        e.tag = tag; e.cin = xcin; e.po = xpo; e.oe = xoe; e.ce = xce; e.act = xact;
        sb_q.push_back(e);
    endtask

    initial begin
        rst = 1'b1;
        cyc(0,0,0, 4'hF,4'h5, 4'hA,4'h3, 6'h05,4'hA,4'h3, 1,0, "R1 reset state");
        rst = 1'b0;
        cyc(0,0,0, 4'hF,4'h9, 4'hC,4'hF, 6'h09,4'hC,4'hF, 1,0, "R1 running");
        cyc(0,0,0, 4'h0,4'h0, 4'hC,4'hF, 6'h09,4'hC,4'hF, 1,0, "R9 all floating");
        cyc(0,0,0, 4'h3,4'h6, 4'hC,4'hF, 6'h0A,4'hC,4'hF, 1,0, "R9 partial drive");
        cyc(0,1,0, 4'hF,4'h3, 4'hC,4'hF, 6'h13,4'hC,4'hF, 1,0, "R8 pin a as input");
        cyc(0,1,1, 4'hF,4'h3, 4'hC,4'hF, 6'h33,4'hC,4'hF, 1,0, "R8 both pins as input");
        cyc(0,0,0, 4'hF,4'h6, 4'h5,4'h6, 6'h06,4'h5,4'h6, 1,0, "R1 prepare");
        // entry via pin a: snapshot of pre-edge values, pin bits masked
        cyc(1,1,0, 4'hF,4'h6, 4'h5,4'h6, 6'h06,4'h5,4'h6, 0,1, "R2 R3 R7 enter on pin a");
        cyc(1,1,0, 4'hF,4'hF, 4'h0,4'hF, 6'h06,4'h5,4'h6, 0,1, "R4 R5 inputs ignored");
        cyc(1,0,1, 4'h0,4'h0, 4'h0,4'hF, 6'h06,4'h5,4'h6, 0,1, "R4 pin b keeps hold");
        // release with a re-raise in the middle
        cyc(1,0,0, 4'hF,4'hC, 4'h3,4'hF, 6'h06,4'h5,4'h6, 0,1, "R6 first low sample");
        cyc(1,1,0, 4'hF,4'hC, 4'h3,4'hF, 6'h06,4'h5,4'h6, 0,1, "R6 re-raise");
        cyc(1,0,0, 4'hF,4'hC, 4'h3,4'hF, 6'h06,4'h5,4'h6, 0,1, "R6 low 1");
        cyc(1,0,0, 4'hF,4'hC, 4'h3,4'hF, 6'h06,4'h5,4'h6, 0,1, "R6 low 2");
        cyc(1,0,0, 4'hF,4'hC, 4'h3,4'hF, 6'h0C,4'h3,4'hF, 1,0, "R6 resumed");
        cyc(1,0,0, 4'hF,4'h5, 4'h9,4'h1, 6'h05,4'h9,4'h1, 1,0, "R7 enabled idle");
        // entry via pin b
        cyc(1,0,1, 4'hF,4'h5, 4'h9,4'h1, 6'h05,4'h9,4'h1, 0,1, "R2 R7 enter on pin b");
        cyc(1,0,1, 4'hF,4'h5, 4'hF,4'h0, 6'h05,4'h9,4'h1, 0,1, "R5 oe held");
        // switching the feature off drops the request
        cyc(0,0,1, 4'hF,4'h5, 4'hF,4'h0, 6'h05,4'h9,4'h1, 0,1, "R6 disable low 1");
        cyc(0,0,1, 4'hF,4'h5, 4'hF,4'h0, 6'h05,4'h9,4'h1, 0,1, "R6 disable low 2");
        cyc(0,0,1, 4'hF,4'h5, 4'hF,4'h0, 6'h25,4'hF,4'h0, 1,0, "R8 released, pin b as input");
        @(posedge clk);
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule